// File: doc/BRIEF.md
# Tagged Sample Buffer with Half-Full Interrupt

This block sits between a converter's sample stream and an 8-bit host port. Each incoming 16-bit word carries a 4-bit channel tag in bits [3:0] and a 12-bit conversion result in bits [15:4]. The words are held in a first-in first-out store of 1024 entries. The host takes each word out in two byte reads, low byte first, then high byte.

Once the store reaches half its depth, the block raises a latched interrupt. The host can then take out a fixed block of 512 words without polling for each one. All host commands are strobes: a write to the right offset acts, and the data byte does not matter, except for the enable command, which uses bit 0. A status byte shows whether the store is empty, whether it is at least half full, and whether a sample was lost because the store was full.

Top module: `tagged_sample_fifo`

## Requirements
- R1: After reset the store is empty, the interrupt is low and sample capture is disabled. The status byte at offset 25 reads 8'h01, with bit 0 = empty, bit 1 = half-full (count >= 512), bit 2 = overflow and bits [7:3] = 0.
- R2: A host write to offset 6 sets capture enable from data bit 0. While capture is disabled, incoming samples are dropped: they are not stored and they do not set overflow.
- R3: A read at offset 23 returns bits [7:0] of the head word, that is channel [3:0] and data [3:0]. A read at offset 24 returns bits [15:8].
- R4: Only a read strobe at offset 24 advances the head. Repeated reads at offset 23 return the same byte.
- R5: Words leave the store in the order they were accepted.
- R6: The interrupt sets one cycle after the count goes from below 512 to 512 or more. It then stays high.
- R7: A host write to offset 20 drops the interrupt. The interrupt does not set again while half-full stays high.
- R8: A sample that arrives while 1024 words are held is dropped and sets overflow. Overflow stays set until a flush, even after the store has drained.
- R9: A host write to offset 25 empties the store and clears half-full, overflow and the interrupt. The next accepted sample is read back first.
- R10: A high-byte read strobe while the store is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample present this cycle |
| samp_data | input | 16 | Tagged sample: channel [3:0], data [15:4] |
| host_addr | input | 5 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Byte selected by host_addr |
| irq | output | 1 | Latched half-full interrupt |

## Verification
The hardest state to reach from the ports is overflow. It needs all 1024 entries filled, then one more sample while capture is still enabled. After that, the entire store has to be drained to show two things: the extra word was never stored, and overflow stays set on an empty store. The bench does this by pushing 1024 numbered words and one marked extra word. It then takes out every entry through the byte port, compares each one against a scoreboard queue, and finally checks that overflow only clears on a flush. The interrupt edge is checked the same way, at the 511th and 512th pushes, with a clear in between.

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo #(
  parameter int DEPTH      = 1024,
  parameter int DW         = 16,
  parameter int AW         = 5,
  parameter int OFS_ENABLE = 6,
  parameter int OFS_IRQCLR = 20,
  parameter int OFS_LO     = 23,
  parameter int OFS_HI     = 24,
  parameter int OFS_CTRL   = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_valid,
  input  logic [DW-1:0] samp_data,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  output logic [7:0]    host_rdata,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] A_EN  = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_CLR = AW'(OFS_IRQCLR);
  localparam logic [AW-1:0] A_LO  = AW'(OFS_LO);
  localparam logic [AW-1:0] A_HI  = AW'(OFS_HI);
  localparam logic [AW-1:0] A_CTL = AW'(OFS_CTRL);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          en, ovf, half_d;

  wire unused_wdata = ^host_wdata[7:1];

  wire flush = host_wr && host_addr == A_CTL;
  wire clr   = host_wr && host_addr == A_CLR;
  wire empty = count == '0;
  wire full  = count == FULL_CNT;
  wire half  = count >= HALF_CNT;
  wire pop   = host_rd && host_addr == A_HI && !empty && !flush;
  wire take  = samp_valid && en && !flush;
  wire push  = take && !full;
  wire drop  = take && full;
  wire [DW-1:0] head = mem[rp];

  always_ff @(posedge clk)
    if (push) mem[wp] <= samp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      en <= 1'b0; ovf <= 1'b0; half_d <= 1'b0; irq <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_EN) en <= host_wdata[0];
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0;
        ovf <= 1'b0; half_d <= 1'b0; irq <= 1'b0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        count  <= count + CW'(push) - CW'(pop);
        if (drop) ovf <= 1'b1;
        half_d <= half;
        if (half && !half_d) irq <= 1'b1;
        else if (clr)        irq <= 1'b0;
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_LO:    host_rdata = head[7:0];
      A_HI:    host_rdata = head[15:8];
      A_CTL:   host_rdata = {5'b0, ovf, half, empty};
      default: host_rdata = 8'h00;
    endcase
  end

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !flush |=> ovf);
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && samp_valid && en && !flush && !pop |=> full && ovf);
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr && !flush |=> irq);
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !samp_valid |=> empty && $stable(rp));
  a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !host_wr |=> count <= $past(count) && $stable(ovf));
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !ovf && !irq);
  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
endmodule

// File: tb/tb_tagged_sample_fifo.sv
module tb_tagged_sample_fifo;
  logic clk = 0, rst_n = 0;
  logic samp_valid = 0;
  logic [15:0] samp_data = '0;
  logic [4:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic irq;
  int errors = 0, checks = 0;
  logic [15:0] q[$];

  tagged_sample_fifo dut (.*);

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(int a, int d);
    @(negedge clk); host_addr = 5'(a); host_wdata = 8'(d); host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic push(logic [15:0] d, bit stored);
    @(negedge clk); samp_valid = 1; samp_data = d;
    @(negedge clk); samp_valid = 0;
    if (stored) q.push_back(d);
  endtask

  task automatic rd_byte(int a, output logic [7:0] v);
    @(negedge clk); host_addr = 5'(a); host_rd = 1; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic peek_status(output logic [7:0] v);
    @(negedge clk); host_addr = 5'd25; #1 v = host_rdata;
  endtask

  // scoreboard monitor: takes a word out through the byte port and compares
  task automatic read_word(string req);
    logic [7:0] lo, hi;
    logic [15:0] exp;
    @(negedge clk); host_addr = 5'd23; host_rd = 1; #1 lo = host_rdata;
    @(negedge clk); host_addr = 5'd24; #1 hi = host_rdata;
    @(negedge clk); host_rd = 0;
    exp = q.size() > 0 ? q.pop_front() : 16'hxxxx;
    chk({hi, lo} === exp, req, {hi, lo}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] s, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek_status(s);
    chk(s == 8'h01, "R1 reset status", s, 8'h01);
    chk(irq == 0, "R1 reset irq", irq, 0);
    push(16'h1111, 0);                             // R1/R2: disabled after reset
    peek_status(s);
    chk(s == 8'h01, "R2 disabled at reset drops", s, 8'h01);

    host_write(6, 8'hFF);
    push(16'hABC3, 1); push(16'h5A57, 1); push(16'h0F0A, 1);
    rd_byte(23, b);
    chk(b == 8'hC3, "R3 low byte", b, 8'hC3);
    rd_byte(23, b);
    chk(b == 8'hC3, "R4 low read does not advance", b, 8'hC3);
    read_word("R3 word");
    read_word("R5 order 2");
    read_word("R5 order 3");
    peek_status(s);
    chk(s == 8'h01, "R5 drained empty", s, 8'h01);

    rd_byte(24, b);                                // R10 pop on empty
    push(16'h7E21, 1);
    read_word("R10 pop on empty ignored");
    peek_status(s);
    chk(s == 8'h01, "R10 empty after", s, 8'h01);

    host_write(6, 8'h00);
    push(16'h2222, 0); push(16'h3333, 0);
    peek_status(s);
    chk(s == 8'h01, "R2 disabled drops", s, 8'h01);
    host_write(6, 8'h01);

    for (int i = 0; i < 511; i++) push(16'(i * 16 + (i % 16)), 1);
    @(negedge clk);
    chk(irq == 0, "R6 no irq at 511", irq, 0);
    peek_status(s);
    chk(s == 8'h00, "R6 status at 511", s, 8'h00);
    push(16'hF00F, 1);
    @(negedge clk);
    chk(irq == 1, "R6 irq at 512", irq, 1);
    peek_status(s);
    chk(s == 8'h02, "R6 half-full flag", s, 8'h02);
    repeat (3) @(negedge clk);
    chk(irq == 1, "R6 irq held", irq, 1);
    host_write(20, 8'h00);
    @(negedge clk);
    chk(irq == 0, "R7 irq cleared", irq, 0);
    push(16'hBEEF, 1);
    @(negedge clk);
    chk(irq == 0, "R7 no re-set while half", irq, 0);
    for (int i = 0; i < 513; i++) read_word("R5 block drain");
    peek_status(s);
    chk(s == 8'h01, "R5 empty after drain", s, 8'h01);

    for (int i = 0; i < 1024; i++) push(16'(i ^ 16'h9C00), 1);
    chk(irq == 1, "R6 irq on refill", irq, 1);
    push(16'hDEAD, 0);
    peek_status(s);
    chk(s == 8'h06, "R8 overflow full", s, 8'h06);
    for (int i = 0; i < 1024; i++) read_word("R8 stored words");
    peek_status(s);
    chk(s == 8'h05, "R8 sticky when empty", s, 8'h05);

    push(16'h1234, 1); push(16'h5678, 1);
    host_write(25, 8'h00);
    q.delete();
    @(negedge clk);
    peek_status(s);
    chk(s == 8'h01, "R9 flush status", s, 8'h01);
    chk(irq == 0, "R9 flush clears irq", irq, 0);
    push(16'hCAFE, 1);
    read_word("R9 first after flush");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule